// File: doc/BRIEF.md
# Read-Then-Branch Chain Splitter

This engine sits in front of a channel executor that fetches a whole command chain from memory before running any of it. Such an executor cannot run a chain in which a read loads new commands that a following branch then jumps into, because the branch target was fetched before the read filled it. Given a start slot, the splitter walks the chain in memory and follows branches to their targets. It stops at the first read that has its chain flag set and sits directly in front of a branch. It clears that read's chain flag in memory and starts the executor on the shortened segment. When the segment completes, it starts again from the branch slot.

Each restart makes the executor fetch the remaining commands, and the data they need, fresh from memory. The loop ends when a scanned segment holds no such pair. That segment is issued as it is, and the splitter reports completion. An executor error, or a scan that runs too long, ends the job with the error flag set.

Memory is organised as 64-bit command slots with a one-cycle read latency. Slot addresses are command addresses divided by eight.

Top module: `chain_splitter`

## Requirements
- R1: After reset `busy`, `done`, `error`, `ssch_req`, `mem_rd` and `mem_wr` are all low.
- R2: Command word layout: opcode in bits [63:56], where 0x02 is a read and 0x08 is a branch. The flag byte is bits [31:24], with the chain flag at bit 30 (0x40). A branch target is a byte address in bits [55:32], and its slot is that address divided by 8.
- R3: A read with the chain flag set, followed in the next slot by a branch, is written back to its slot before issue with only bit 30 cleared.
- R4: Each segment is issued by a single one-cycle `ssch_req` pulse, with `ssch_addr` equal to the slot where that segment begins. The first segment begins at `start_addr`.
- R5: After a split segment completes without error, the next segment begins at the branch slot (read slot + 1). Its scan reads memory anew, so commands written during the previous segment are used.
- R6: The scan follows branches to their target slot. It ends at the first non-branch command whose chain flag is clear. A job ends with one `done` pulse when a segment with no pair completes.
- R7: A segment containing no pair is issued with no memory write.
- R8: An executor completion with `ssch_err` high ends the job with `done` and `error` high together, and no further `ssch_req`.
- R9: A scan of up to SCAN_LIMIT (64) commands is accepted. Fetching command SCAN_LIMIT+1 in one scan ends the job with `error` and no issue.
- R10: `start` is ignored while `busy` is high.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job at `start_addr` |
| start_addr | input | ADDR_W | First slot of the chain |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job-end pulse |
| error | output | 1 | Job ended in error (valid with `done`) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Slot address for read or write |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after `mem_rd` |
| ssch_req | output | 1 | Start-segment request to the executor |
| ssch_addr | output | ADDR_W | First slot of the segment |
| ssch_done | input | 1 | Executor completion pulse |
| ssch_err | input | 1 | Executor error, valid with `ssch_done` |

## Verification
The hardest case to reach is the refetch after a split. The commands the second segment scans do not exist in memory when the job starts. They come into being only while the first segment is in flight. The bench's executor model writes the loaded program into memory during a chosen segment, before it signals completion, just as a real read would. The bench then checks that the next segment's start and the second chain-flag clear both depend on those late contents. A sweep over chain lengths and pair positions, and scans of exactly 64 and 65 commands, cover the placement and limit boundaries.

// File: rtl/chain_split_pkg.sv
package chain_split_pkg;
  localparam logic [7:0] OPC_READ  = 8'h02;
  localparam logic [7:0] OPC_TIC   = 8'h08;
  localparam int         CHAIN_BIT = 30;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CUR, S_WT_CUR, S_RD_NXT, S_WT_NXT,
    S_WRITE, S_ISSUE, S_WAIT, S_FINISH
  } split_state_e;

  function automatic logic [7:0] cmd_opcode(input logic [63:0] w);
    return w[63:56];
  endfunction

  function automatic logic cmd_chained(input logic [63:0] w);
    return w[CHAIN_BIT];
  endfunction

  function automatic logic [63:0] cmd_strip_chain(input logic [63:0] w);
    logic [63:0] r;
    r = w;
    r[CHAIN_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [23:0] cmd_target(input logic [63:0] w);
    return w[55:32];
  endfunction
endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import chain_split_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [63:0]       word,
  output logic              is_read,
  output logic              is_tic,
  output logic              chained,
  output logic [ADDR_W-1:0] tgt_slot
);
  logic [23:0] tgt_byte;

  always_comb begin
    tgt_byte = cmd_target(word);
    is_read  = (cmd_opcode(word) == OPC_READ);
    is_tic   = (cmd_opcode(word) == OPC_TIC);
    chained  = cmd_chained(word);
    tgt_slot = tgt_byte[ADDR_W+2:3];
  end
endmodule

// File: rtl/scan_limiter.sv
module scan_limiter #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic over
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt;

  assign over = tick && (cnt == CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (tick && !over) cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(LIMIT)); // R9
endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
  import chain_split_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [63:0]       rdata,
  input  logic              c_read,
  input  logic              c_tic,
  input  logic              c_chain,
  input  logic [ADDR_W-1:0] c_tgt,
  input  logic              scan_over,
  output logic              scan_clear,
  output logic              scan_tick,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic              ssch_req,
  output logic [ADDR_W-1:0] ssch_addr,
  input  logic              ssch_done,
  input  logic              ssch_err
);
  split_state_e      state;
  logic [ADDR_W-1:0] seg_base, cur;
  logic [63:0]       held;
  logic              pair_pend, err_flag;
  logic              pair_hit, exec_fail;

  assign pair_hit  = (state == S_WT_NXT) && c_tic;
  assign exec_fail = (state == S_WAIT) && ssch_done && ssch_err;
  assign scan_tick = (state == S_WT_CUR);

  always_comb begin
    scan_clear = (state == S_IDLE) ||
                 ((state == S_WAIT) && ssch_done && pair_pend);
    busy      = (state != S_IDLE);
    done      = (state == S_FINISH);
    error     = (state == S_FINISH) && err_flag;
    mem_rd    = (state == S_RD_CUR) || (state == S_RD_NXT);
    mem_wr    = (state == S_WRITE);
    mem_addr  = (state == S_RD_NXT) ? cur + 1'b1 : cur;
    mem_wdata = cmd_strip_chain(held);
    ssch_req  = (state == S_ISSUE);
    ssch_addr = seg_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; seg_base <= '0; cur <= '0; held <= '0;
      pair_pend <= 1'b0; err_flag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          seg_base <= start_addr; cur <= start_addr;
          pair_pend <= 1'b0; err_flag <= 1'b0; state <= S_RD_CUR;
        end
        S_RD_CUR: state <= S_WT_CUR;
        S_WT_CUR: begin
          held <= rdata;
          if (scan_over) begin
            err_flag <= 1'b1; state <= S_FINISH;
          end else if (c_tic) begin
            cur <= c_tgt; state <= S_RD_CUR;
          end else if (!c_chain) begin
            state <= S_ISSUE;
          end else if (c_read) begin
            state <= S_RD_NXT;
          end else begin
            cur <= cur + 1'b1; state <= S_RD_CUR;
          end
        end
        S_RD_NXT: state <= S_WT_NXT;
        S_WT_NXT: begin
          if (c_tic) begin
            pair_pend <= 1'b1; state <= S_WRITE;
          end else begin
            cur <= cur + 1'b1; state <= S_RD_CUR;
          end
        end
        S_WRITE: state <= S_ISSUE;
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (ssch_done) begin
          if (ssch_err) begin
            err_flag <= 1'b1; state <= S_FINISH;
          end else if (pair_pend) begin
            seg_base <= cur + 1'b1; cur <= cur + 1'b1;
            pair_pend <= 1'b0; state <= S_RD_CUR;
          end else begin
            state <= S_FINISH;
          end
        end
        S_FINISH: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R11
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ssch_req |=> !ssch_req); // R4
  AST_WR_CLEARS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata[63:56] == OPC_READ) && !mem_wdata[CHAIN_BIT]); // R3
  AST_WR_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    pair_hit |=> mem_wr); // R3
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fail |=> done && error && !ssch_req); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done); // R8
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy); // R10
endmodule

// File: rtl/chain_splitter.sv
module chain_splitter #(
  parameter int ADDR_W     = 8,
  parameter int SCAN_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic              ssch_req,
  output logic [ADDR_W-1:0] ssch_addr,
  input  logic              ssch_done,
  input  logic              ssch_err
);
  logic              c_read, c_tic, c_chain;
  logic [ADDR_W-1:0] c_tgt;
  logic              scan_clear, scan_tick, scan_over;

  cmd_classify #(.ADDR_W(ADDR_W)) u_cls (
    .word(mem_rdata), .is_read(c_read), .is_tic(c_tic),
    .chained(c_chain), .tgt_slot(c_tgt));

  scan_limiter #(.LIMIT(SCAN_LIMIT)) u_lim (
    .clk(clk), .rst_n(rst_n), .clear(scan_clear),
    .tick(scan_tick), .over(scan_over));

  split_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .rdata(mem_rdata), .c_read(c_read), .c_tic(c_tic), .c_chain(c_chain),
    .c_tgt(c_tgt), .scan_over(scan_over), .scan_clear(scan_clear),
    .scan_tick(scan_tick), .busy(busy), .done(done), .error(error),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .ssch_req(ssch_req), .ssch_addr(ssch_addr),
    .ssch_done(ssch_done), .ssch_err(ssch_err));
endmodule

// File: tb/tb_chain_splitter.sv
module tb_chain_splitter;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] start_addr = '0;
  logic busy, done, error, mem_rd, mem_wr, ssch_req;
  logic [7:0] mem_addr, ssch_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic ssch_done = 1'b0, ssch_err = 1'b0;

  logic [63:0] mem [256];
  logic [63:0] snap [256];
  int n_chk = 0, n_fail = 0;
  int seg_log [8];
  int nseg, test_id, err_seg;
  logic job_err;
  logic poke_busy = 1'b0;

  always #10 clk = ~clk;

  chain_splitter dut (.*);

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  function automatic logic [63:0] mkcmd(input logic [7:0] op, input bit ch,
                                        input int tgt_slot);
    logic [23:0] t;
    t = 24'(tgt_slot * 8);
    return {op, t, (ch ? 8'h40 : 8'h00), 24'h0};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 64'h0;
  endtask

  task automatic take_snap();
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
  endtask

  // executor side effects: model a read loading new commands
  task automatic exec_hook(input int seg);
    if (test_id == 3 && seg == 1) begin
      mem[32] = mkcmd(8'h02, 1, 0);
      mem[33] = mkcmd(8'h08, 1, 64);
    end
    if (test_id == 3 && seg == 2) mem[64] = mkcmd(8'h02, 0, 0);
  endtask

  task automatic run_job(input int addr);
    int guard;
    nseg = 0; job_err = 1'b0; guard = 0;
    @(negedge clk); start = 1'b1; start_addr = 8'(addr);
    @(negedge clk); start = 1'b0;
    while (guard < 5000) begin
      guard++;
      if (done) begin job_err = error; break; end
      if (ssch_req) begin
        if (nseg < 8) seg_log[nseg] = int'(ssch_addr);
        nseg++;
        exec_hook(nseg);
        @(negedge clk);
        if (poke_busy) begin
          start = 1'b1; start_addr = 8'd200;
          @(negedge clk); start = 1'b0;
        end
        repeat (2) @(negedge clk);
        ssch_done = 1'b1; ssch_err = (nseg == err_seg);
        @(negedge clk); ssch_done = 1'b0; ssch_err = 1'b0;
      end else @(negedge clk);
    end
    if (guard >= 5000) chk(0, "job timeout", guard, 0);
    @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 200000) begin @(posedge clk); wd++; end
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected <200000", wd);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_mem(); err_seg = -1; test_id = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error, "R1 status", {busy, done, error}, 0);
    chk(!ssch_req && !mem_rd && !mem_wr, "R1 strobes", {ssch_req, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 / R6 / R10: chain with no pair, start poked while busy
    test_id = 2; clear_mem();
    mem[10] = mkcmd(8'h03, 1, 0); mem[11] = mkcmd(8'h02, 1, 0);
    mem[12] = mkcmd(8'h01, 1, 0); mem[13] = mkcmd(8'h02, 0, 0);
    take_snap(); poke_busy = 1'b1;
    run_job(10); poke_busy = 1'b0;
    chk(nseg == 1, "R10 one segment despite start while busy", nseg, 1);
    chk(seg_log[0] == 10, "R4 first segment addr", seg_log[0], 10);
    chk(!job_err, "R6 clean end", job_err, 0);
    for (int i = 10; i < 14; i++)
      chk(mem[i] == snap[i], "R7 chain untouched", mem[i], snap[i]);

    // R2 / R3 / R5 / R6: boot-like refetch via executor-loaded program
    test_id = 3; clear_mem();
    mem[0] = mkcmd(8'h02, 1, 0); mem[1] = mkcmd(8'h08, 1, 32);
    mem[32] = mkcmd(8'h03, 0, 0);
    run_job(0);
    chk(nseg == 3, "R5 segment count", nseg, 3);
    chk(seg_log[0] == 0, "R4 seg0", seg_log[0], 0);
    chk(seg_log[1] == 1, "R5 reissue at branch", seg_log[1], 1);
    chk(seg_log[2] == 33, "R6 followed branch then reissue", seg_log[2], 33);
    chk(mem[0] == mkcmd(8'h02, 0, 0), "R3 first read chain cleared", mem[0], mkcmd(8'h02, 0, 0));
    chk(mem[32] == mkcmd(8'h02, 0, 0), "R5 refetched read chain cleared", mem[32], mkcmd(8'h02, 0, 0));
    chk(mem[33] == mkcmd(8'h08, 1, 64), "R2 branch word kept", mem[33], mkcmd(8'h08, 1, 64));
    chk(!job_err, "R6 no error", job_err, 0);

    // R8: executor error on first segment
    test_id = 8; clear_mem();
    mem[0] = mkcmd(8'h02, 1, 0); mem[1] = mkcmd(8'h08, 1, 32);
    mem[32] = mkcmd(8'h03, 0, 0);
    err_seg = 1;
    run_job(0);
    err_seg = -1;
    chk(nseg == 1, "R8 no reissue", nseg, 1);
    chk(job_err, "R8 error flag", job_err, 1);

    // R3 / R4 / R5 sweep: chain length n, pair at position p
    test_id = 4;
    for (int n = 3; n <= 8; n++) begin
      for (int p = 0; p <= n - 3; p++) begin
        clear_mem();
        for (int i = 0; i < n; i++) begin
          if (i == p) mem[8+i] = mkcmd(8'h02, 1, 0);
          else if (i == p + 1) mem[8+i] = mkcmd(8'h08, 1, 8 + p + 2);
          else mem[8+i] = mkcmd((i % 2) ? 8'h02 : 8'h01, i < n - 1, 0);
        end
        take_snap();
        run_job(8);
        chk(nseg == 2, "R5 sweep segments", nseg, 2);
        chk(seg_log[0] == 8, "R4 sweep seg0", seg_log[0], 8);
        chk(seg_log[1] == 8 + p + 1, "R5 sweep reissue", seg_log[1], 8 + p + 1);
        for (int i = 0; i < n; i++) begin
          logic [63:0] e;
          e = snap[8+i];
          if (i == p) e[30] = 1'b0;
          chk(mem[8+i] == e, "R3 sweep memory", mem[8+i], e);
        end
        chk(!job_err, "R6 sweep clean", job_err, 0);
      end
    end

    // R9: exactly the limit is accepted
    test_id = 9; clear_mem();
    for (int i = 0; i < 64; i++) mem[120+i] = mkcmd(8'h01, i < 63, 0);
    run_job(120);
    chk(nseg == 1 && !job_err, "R9 64 commands accepted", {nseg, job_err}, 2);
    // R9: one more is rejected
    clear_mem();
    for (int i = 0; i < 65; i++) mem[120+i] = mkcmd(8'h01, i < 64, 0);
    run_job(120);
    chk(nseg == 0, "R9 65 commands no issue", nseg, 0);
    chk(job_err, "R9 65 commands error", job_err, 1);
    // R9 / R6: self-branch loop stopped
    clear_mem();
    mem[100] = mkcmd(8'h08, 1, 100);
    run_job(100);
    chk(nseg == 0 && job_err, "R9 branch loop", {nseg, job_err}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule